// File: doc/BRIEF.md
# March Test BIST Sequencer

This block is a built-in self-test sequencer for a bit-wide RAM of `DEPTH` words. On a start request it takes an algorithm code, then walks the memory through that algorithm's list of march elements. Each element sweeps every address in one direction, ascending or descending, and applies a short fixed list of reads and writes to each cell before moving to the next cell. The RAM is external: the sequencer drives address, write enable, read enable and write data, and the RAM returns read data one cycle after a read strobe.

Every read carries an expected bit. The sequencer compares the returned bit against it. The first mismatch of a run raises a sticky fail flag and captures the failing address and the index of the element that was running. The run then continues to its end, and completion is marked by a one-cycle done pulse. The sequencer is used by pulsing start with a valid code and waiting for done. It then reads the fail flag and the captured location.

Top module: `march_bist`

## Requirements
- R1: While reset is held and right after it, busy, done, failFlag, failAddr, failElem, memWe, memRe, memWdata and memAddr are all 0.
- R2: Valid algorithm codes are 0 MATS, 1 MATS+, 2 MATS++, 3 March X, 4 March C-, 5 March Y. A start with code 6 or 7 is ignored: busy stays 0 and no memory operation is issued.
- R3: The elements run in this order, with U for ascending and D for descending addresses. Code 0: U(w0) U(r0,w1) D(r1). Code 1: U(w0) U(r0,w1) D(r1,w0). Code 2: U(w0) U(r0,w1) D(r1,w0,r0). Code 3: U(w0) U(r0,w1) D(r1,w0) U(r0). Code 4: U(w0) U(r0,w1) U(r1,w0) D(r0,w1) D(r1,w0) U(r0). Code 5: U(w0) U(r0,w1,r1) D(r1,w0,r0) U(r0). All operations of an element are applied to one address before the address steps.
- R4: Exactly one operation is issued per cycle, with no gaps. The first operation appears in the cycle after start is sampled. The total number of operations is 4, 5, 6, 6, 10 or 8 times DEPTH for codes 0 to 5. busy is 1 from the first operation until done. done is high for one cycle, in the second cycle after the last operation.
- R5: A write drives memWdata with its value and memWe=1. A read drives memRe=1, and its expected value is compared with memRdata in the following cycle.
- R6: The first mismatch of a run sets failFlag and captures the read's address in failAddr and its 0-based element index in failElem. Later mismatches change none of them.
- R7: After a mismatch the run continues to the end, with the same operation count and done timing as a passing run.
- R8: A start asserted while busy is 1 has no effect on the operation stream or on the done timing.
- R9: An accepted start clears failFlag, failAddr and failElem before the first read of the new run is compared.
- R10: memWe and memRe are never 1 in the same cycle, and neither is 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled while idle |
| algoSel | input | 3 | Algorithm code |
| memAddr | output | AW | RAM address |
| memWe | output | 1 | RAM write strobe |
| memRe | output | 1 | RAM read strobe |
| memWdata | output | 1 | RAM write bit |
| memRdata | input | 1 | RAM read bit, valid the cycle after memRe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| failFlag | output | 1 | Sticky mismatch flag |
| failAddr | output | AW | Address of first mismatch |
| failElem | output | 3 | Element index of first mismatch |

## Verification
The bench compares every operation, in order, against a stream it builds from the element lists. A wrong sweep direction, a skipped operation or an address stepped one cell too early shows up as a mismatch at that exact operation. Faulty RAM models are used to check the capture logic: a stuck-at-0 cell that only a descending read can expose, two stuck-at-1 cells that test whether a second mismatch overwrites the first capture, and an aliased write address. A design that captured the last mismatch, or that stopped early on a failure, would report the wrong address or a short operation count. A start pulse in the middle of a March C- run, and a start with an invalid code, check that a sequencer taking stray starts either restarts its stream or issues operations it should not.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int ALGO_W = 3;
  localparam int ELEM_W = 3;

  localparam logic [ALGO_W-1:0] ALG_MATS    = 3'd0;
  localparam logic [ALGO_W-1:0] ALG_MATS_P  = 3'd1;
  localparam logic [ALGO_W-1:0] ALG_MATS_PP = 3'd2;
  localparam logic [ALGO_W-1:0] ALG_MX      = 3'd3;
  localparam logic [ALGO_W-1:0] ALG_MCM     = 3'd4;
  localparam logic [ALGO_W-1:0] ALG_MY      = 3'd5;

  typedef struct packed {
    logic isWr;
    logic val;
  } opT;

  typedef struct packed {
    logic       desc;
    logic [1:0] nOps;
    opT         op0;
    opT         op1;
    opT         op2;
  } elemT;

  typedef struct packed {
    logic clr;
    logic rdIssue;
    logic rdExp;
  } strobeT;

  function automatic opT rd(input logic v);
    return '{isWr: 1'b0, val: v};
  endfunction

  function automatic opT wr(input logic v);
    return '{isWr: 1'b1, val: v};
  endfunction

  localparam opT OP_NONE = '{isWr: 1'b0, val: 1'b0};

  function automatic elemT mkE(input logic d, input logic [1:0] n,
                               input opT a, input opT b, input opT c);
    return '{desc: d, nOps: n, op0: a, op1: b, op2: c};
  endfunction

  function automatic logic algoValid(input logic [ALGO_W-1:0] a);
    return a <= ALG_MY;
  endfunction

  function automatic logic [ELEM_W-1:0] elemCount(input logic [ALGO_W-1:0] a);
    case (a)
      ALG_MX, ALG_MY: return 3'd4;
      ALG_MCM:        return 3'd6;
      default:        return 3'd3;
    endcase
  endfunction

  function automatic elemT elemOf(input logic [ALGO_W-1:0] a, input logic [ELEM_W-1:0] i);
    elemT e;
    e = '0;
    if (i == 3'd0) begin
      e = mkE(1'b0, 2'd1, wr(1'b0), OP_NONE, OP_NONE);
    end else if (i == 3'd1) begin
      if (a == ALG_MY) e = mkE(1'b0, 2'd3, rd(1'b0), wr(1'b1), rd(1'b1));
      else             e = mkE(1'b0, 2'd2, rd(1'b0), wr(1'b1), OP_NONE);
    end else begin
      case (a)
        ALG_MATS:
          if (i == 3'd2) e = mkE(1'b1, 2'd1, rd(1'b1), OP_NONE, OP_NONE);
        ALG_MATS_P:
          if (i == 3'd2) e = mkE(1'b1, 2'd2, rd(1'b1), wr(1'b0), OP_NONE);
        ALG_MATS_PP:
          if (i == 3'd2) e = mkE(1'b1, 2'd3, rd(1'b1), wr(1'b0), rd(1'b0));
        ALG_MX:
          case (i)
            3'd2:    e = mkE(1'b1, 2'd2, rd(1'b1), wr(1'b0), OP_NONE);
            3'd3:    e = mkE(1'b0, 2'd1, rd(1'b0), OP_NONE, OP_NONE);
            default: e = '0;
          endcase
        ALG_MCM:
          case (i)
            3'd2:    e = mkE(1'b0, 2'd2, rd(1'b1), wr(1'b0), OP_NONE);
            3'd3:    e = mkE(1'b1, 2'd2, rd(1'b0), wr(1'b1), OP_NONE);
            3'd4:    e = mkE(1'b1, 2'd2, rd(1'b1), wr(1'b0), OP_NONE);
            3'd5:    e = mkE(1'b0, 2'd1, rd(1'b0), OP_NONE, OP_NONE);
            default: e = '0;
          endcase
        ALG_MY:
          case (i)
            3'd2:    e = mkE(1'b1, 2'd3, rd(1'b1), wr(1'b0), rd(1'b0));
            3'd3:    e = mkE(1'b0, 2'd1, rd(1'b0), OP_NONE, OP_NONE);
            default: e = '0;
          endcase
        default: e = '0;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ALGO_W-1:0] algoSel,
  output logic [AW-1:0]     memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic              memWdata,
  output logic              busy,
  output logic              done,
  output strobeT            strobe,
  output logic [AW-1:0]     rdAddr,
  output logic [ELEM_W-1:0] rdElem
);

  localparam logic [AW-1:0] MAX_ADDR = AW'(DEPTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} stateE;

  stateE             stateQ;
  logic [ALGO_W-1:0] algoQ;
  logic [ELEM_W-1:0] elemQ;
  logic [1:0]        opQ;
  logic [AW-1:0]     addrQ;
  logic              doneQ;

  elemT curE;
  opT   curOp;
  logic nxtDesc, firstDesc;
  logic lastOp, lastAddr, lastElem, accept, running;

  always_comb begin
    curE      = elemOf(algoQ, elemQ);
    nxtDesc   = elemOf(algoQ, elemQ + 3'd1).desc;
    firstDesc = elemOf(algoSel, 3'd0).desc;
    case (opQ)
      2'd0:    curOp = curE.op0;
      2'd1:    curOp = curE.op1;
      default: curOp = curE.op2;
    endcase
    lastOp   = (opQ == curE.nOps - 2'd1);
    lastAddr = curE.desc ? (addrQ == '0) : (addrQ == MAX_ADDR);
    lastElem = (elemQ == elemCount(algoQ) - 3'd1);
    running  = (stateQ == ST_RUN);
    accept   = (stateQ == ST_IDLE) && start && algoValid(algoSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      algoQ  <= '0;
      elemQ  <= '0;
      opQ    <= '0;
      addrQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (accept) begin
            algoQ  <= algoSel;
            elemQ  <= '0;
            opQ    <= '0;
            addrQ  <= firstDesc ? MAX_ADDR : '0;
            stateQ <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!lastOp) begin
            opQ <= opQ + 2'd1;
          end else begin
            opQ <= '0;
            if (!lastAddr) begin
              addrQ <= curE.desc ? addrQ - 1'b1 : addrQ + 1'b1;
            end else if (!lastElem) begin
              elemQ <= elemQ + 3'd1;
              addrQ <= nxtDesc ? MAX_ADDR : '0;
            end else begin
              stateQ <= ST_DRAIN;
            end
          end
        end
        default: begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
      endcase
    end
  end

  assign memAddr  = running ? addrQ : '0;
  assign memWe    = running && curOp.isWr;
  assign memRe    = running && !curOp.isWr;
  assign memWdata = running && curOp.isWr && curOp.val;
  assign busy     = (stateQ != ST_IDLE);
  assign done     = doneQ;

  assign strobe.clr     = accept;
  assign strobe.rdIssue = running && !curOp.isWr;
  assign strobe.rdExp   = curOp.val;
  assign rdAddr         = addrQ;
  assign rdElem         = elemQ;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R10
  AST_STROBES_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> busy); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (running && start) |=> busy); // R8
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> (int'(memAddr) < DEPTH)); // R3

endmodule

// File: rtl/march_dpath.sv
module march_dpath
  import march_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [AW-1:0]     rdAddr,
  input  logic [ELEM_W-1:0] rdElem,
  input  logic              memRdata,
  output logic              failFlag,
  output logic [AW-1:0]     failAddr,
  output logic [ELEM_W-1:0] failElem
);

  logic              pendV, pendExp;
  logic [AW-1:0]     pendAddr;
  logic [ELEM_W-1:0] pendElem;
  logic              mismatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendV    <= 1'b0;
      pendExp  <= 1'b0;
      pendAddr <= '0;
      pendElem <= '0;
    end else begin
      pendV <= strobe.rdIssue;
      if (strobe.rdIssue) begin
        pendExp  <= strobe.rdExp;
        pendAddr <= rdAddr;
        pendElem <= rdElem;
      end
    end
  end

  assign mismatch = pendV && (memRdata != pendExp);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) begin
      failFlag <= 1'b0;
      failAddr <= '0;
      failElem <= '0;
    end else if (mismatch && !failFlag) begin
      failFlag <= 1'b1;
      failAddr <= pendAddr;
      failElem <= pendElem;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strobe.clr) |=> failFlag); // R6
  AST_FAIL_INFO_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strobe.clr) |=> ($stable(failAddr) && $stable(failElem))); // R6
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> !failFlag); // R9

endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ALGO_W-1:0] algoSel,
  output logic [AW-1:0]     memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic              memWdata,
  input  logic              memRdata,
  output logic              busy,
  output logic              done,
  output logic              failFlag,
  output logic [AW-1:0]     failAddr,
  output logic [ELEM_W-1:0] failElem
);

  strobeT            strobe;
  logic [AW-1:0]     rdAddr;
  logic [ELEM_W-1:0] rdElem;

  march_ctrl #(.DEPTH(DEPTH), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .algoSel(algoSel),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .busy(busy), .done(done), .strobe(strobe), .rdAddr(rdAddr), .rdElem(rdElem)
  );

  march_dpath #(.AW(AW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .rdElem(rdElem),
    .memRdata(memRdata), .failFlag(failFlag), .failAddr(failAddr), .failElem(failElem)
  );

endmodule

// File: tb/march_bist_test.sv
module march_bist_test;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  typedef struct packed {
    logic          we;
    logic          re;
    logic [AW-1:0] addr;
    logic          data;
  } itemT;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    algoSel = 3'd0;
  logic [AW-1:0] memAddr;
  logic          memWe, memRe, memWdata;
  logic          memRdata = 1'b0;
  logic          busy, done, failFlag;
  logic [AW-1:0] failAddr;
  logic [2:0]    failElem;

  int checks = 0;
  int fails = 0;
  int opsSeen = 0;
  itemT expQ[$];

  logic memArr [DEPTH];
  int faultKind = 0;
  int fA = 0;
  int fB = 0;

  always #2.5 clk = ~clk;

  march_bist #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .start(start), .algoSel(algoSel),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .failFlag(failFlag),
    .failAddr(failAddr), .failElem(failElem)
  );

  // RAM model with injectable faults: 1 stuck-at-0, 2 stuck-at-1 (cells fA, fB), 3 writes to fA land in fB
  function automatic logic cellRead(input int a);
    if (faultKind == 1 && (a == fA || a == fB)) return 1'b0;
    if (faultKind == 2 && (a == fA || a == fB)) return 1'b1;
    return memArr[a];
  endfunction

  function automatic int writeTarget(input int a);
    if (faultKind == 3 && a == fA) return fB;
    return a;
  endfunction

  always @(posedge clk) begin
    if (memWe) memArr[writeTarget(int'(memAddr))] <= memWdata;
    if (memRe) memRdata <= cellRead(int'(memAddr));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (memWe || memRe)) begin
      itemT got, want;
      got = '{we: memWe, re: memRe, addr: memAddr, data: memWe & memWdata};
      opsSeen++;
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected operation: actual %0h expected none", got);
      end else begin
        want = expQ.pop_front();
        if (got !== want) begin
          fails++;
          $display("FAIL R3/R5 operation %0d: actual %0h expected %0h", opsSeen, got, want);
        end
      end
    end
  end

  function automatic string algStr(input int a);
    case (a)
      0: return "Uw0 Ur0w1 Dr1";
      1: return "Uw0 Ur0w1 Dr1w0";
      2: return "Uw0 Ur0w1 Dr1w0r0";
      3: return "Uw0 Ur0w1 Dr1w0 Ur0";
      4: return "Uw0 Ur0w1 Ur1w0 Dr0w1 Dr1w0 Ur0";
      default: return "Uw0 Ur0w1r1 Dr1w0r0 Ur0";
    endcase
  endfunction

  function automatic int cplx(input int a);
    case (a)
      0: return 4;
      1: return 5;
      2: return 6;
      3: return 6;
      4: return 10;
      default: return 8;
    endcase
  endfunction

  task automatic pushStream(input string s);
    int i;
    i = 0;
    while (i < s.len()) begin
      byte dir;
      bit isW [3];
      bit v [3];
      int n;
      n = 0;
      dir = s[i];
      i++;
      while (i < s.len() && s[i] != " ") begin
        isW[n] = (s[i] == "w");
        v[n] = (s[i+1] == "1");
        n++;
        i += 2;
      end
      i++;
      for (int c = 0; c < DEPTH; c++) begin
        int a;
        a = (dir == "D") ? DEPTH - 1 - c : c;
        for (int k = 0; k < n; k++)
          expQ.push_back('{we: isW[k], re: !isW[k], addr: a[AW-1:0], data: isW[k] & v[k]});
      end
    end
  endtask

  task automatic runTest(input int alg, input int kind, input int a, input int b,
                         input bit expF, input int expA, input int expE, input bit midStart);
    int cyc;
    int total;
    faultKind = kind;
    fA = a;
    fB = b;
    for (int c = 0; c < DEPTH; c++) memArr[c] = 1'b1;
    expQ.delete();
    pushStream(algStr(alg));
    total = cplx(alg) * DEPTH;
    opsSeen = 0;
    @(negedge clk);
    algoSel = alg[2:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy === 1'b1, "R4", busy, 1, "busy in first cycle");
    chk(failFlag === 1'b0, "R9", failFlag, 0, "fail cleared by start");
    while (done !== 1'b1 && cyc < 4000) begin
      start = (midStart && cyc == 20);
      if (midStart && cyc == 20) algoSel = 3'd0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc < 4000, "R4", cyc, total + 2, "watchdog");
    chk(cyc == total + 2, midStart ? "R8" : "R4", cyc, total + 2, "cycles to done");
    chk(opsSeen == total, midStart ? "R8" : "R4", opsSeen, total, "operation count");
    chk(expQ.size() == 0, "R3", expQ.size(), 0, "operations left");
    chk(failFlag === expF, expF ? "R7" : "R6", failFlag, expF, "fail flag");
    if (expF) begin
      chk(failAddr == expA[AW-1:0], "R6", failAddr, expA, "fail address");
      chk(failElem == expE[2:0], "R6", failElem, expE, "fail element");
    end
    @(negedge clk);
    chk(done === 1'b0, "R4", done, 0, "done one cycle");
    chk(busy === 1'b0, "R4", busy, 0, "idle after done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, failFlag, memWe, memRe, memWdata} === 6'b0, "R1", busy, 0, "strobes in reset");
    chk(failAddr === '0 && failElem === '0 && memAddr === '0, "R1", failAddr, 0, "capture in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, failFlag, memWe, memRe} === 5'b0, "R1", busy, 0, "after reset");

    runTest(1, 0, 0, 0, 1'b0, 0, 0, 1'b0);   // MATS+ clean
    runTest(0, 1, 9, 9, 1'b1, 9, 2, 1'b0);   // MATS stuck-0 found by descending r1
    runTest(2, 1, 3, 3, 1'b1, 3, 2, 1'b0);   // MATS++ stuck-0
    runTest(3, 2, 5, 9, 1'b1, 5, 1, 1'b0);   // March X two stuck-1 cells: first kept (R6)
    runTest(4, 0, 0, 0, 1'b0, 0, 0, 1'b1);   // March C- with start while busy (R8)
    runTest(5, 1, 0, 0, 1'b1, 0, 1, 1'b0);   // March Y stuck-0 seen by r1 in element 1
    runTest(1, 3, 5, 9, 1'b1, 5, 1, 1'b0);   // MATS+ aliased write
    runTest(1, 0, 0, 0, 1'b0, 0, 0, 1'b0);   // clean run after failure clears (R9)

    // R2: invalid code ignored
    expQ.delete();
    @(negedge clk);
    algoSel = 3'd6;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk(busy === 1'b0 && done === 1'b0, "R2", busy, 0, "invalid code started");
      @(negedge clk);
    end
    algoSel = 3'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R2", busy, 0, "code 7 started");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule